// File: doc/BRIEF.md
# Flag-Setting Compare and Test Unit

This block is the condition-code half of a 32-bit integer datapath. It takes two operands, passes the second one through an immediate logical shifter, and then applies one of eight operations. Four are ordinary data operations: AND, XOR, subtract and add. The other four are probe operations: compare (subtract), compare-negated (add), test (AND) and test-equivalence (XOR). These compute the same values but never request a write of their result.

From the ALU output the unit derives negative, zero, carry and overflow. It keeps them in a 4-bit status register that later conditional logic can read. Probe operations always update that register. Data operations update it only when the set-flags control is high. Flag changes take effect on the rising clock edge of the cycle in which `valid` is high.

The ALU result and the result write-enable are combinational. They are valid during the same cycle as the operation.

Top module: `flagcmp_unit`

## Requirements
- R1: The `op` encoding is 0=AND, 1=XOR, 2=SUB (A minus shifted B), 3=ADD (A plus shifted B), 4=TEST (A AND shifted B), 5=TESTEQ (A XOR shifted B), 6=CMP (A minus shifted B), 7=CMN (A plus shifted B). `result` always shows the value of the selected operation.
- R2: `result_we` is 1 when `valid` is high and `op` is 0..3. It is 0 for `op` 4..7 and whenever `valid` is low.
- R3: `flags` is {N,Z,C,V} in bits 3..0. N is taken from result bit 31. Z is 1 exactly when all 32 result bits are zero.
- R4: For ADD and CMN, C is the carry out of bit 31. For SUB and CMP, C is the carry out of A plus the two's complement of the shifted B, so C=1 means A is unsigned-higher-or-same.
- R5: For the four arithmetic operations, V is 1 when the carry into bit 31 differs from the carry out of bit 31. Example: CMP of 0x7FFFFFFF with 0xFFFFFFFF gives flags 1001.
- R6: The shifter shifts left when `shift_right`=0 and right when `shift_right`=1, by `shift_amt` positions (0..31), filling with zeros. For the logical operations C becomes the last bit shifted out. Example: right shift by 1 of 0xFFFFFFFF gives C=1. With `shift_amt`=0, C keeps its current value.
- R7: For the logical operations (AND, XOR, TEST, TESTEQ), V keeps its current value.
- R8: Operations 4..7 update the flags regardless of `set_flags`. Operations 0..3 update the flags only when `set_flags`=1; otherwise the flags hold their values.
- R9: After reset the flags are 0000. An update takes effect at the rising edge of the cycle in which `valid` is high. With `valid` low, the flags hold.
- R10: CMN of 0x7FFFFFFF with 0xFFFFFFFF shifted left by 2 gives result 0x7FFFFFFB and flags 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Operation strobe for this cycle |
| op | input | 3 | Operation select (see R1) |
| set_flags | input | 1 | Flag update enable for operations 0..3 |
| a | input | 32 | First operand |
| b | input | 32 | Second operand, before the shifter |
| shift_right | input | 1 | Shift direction: 0 left, 1 right |
| shift_amt | input | 5 | Shift distance |
| result | output | 32 | ALU output |
| result_we | output | 1 | Result write request |
| flags | output | 4 | Status register {N,Z,C,V} |

## Verification
The assertions check several properties on every cycle. They check the reset value of the status register and that it holds whenever no update is requested. They also check that, after any update, N and Z match the result of the previous cycle, and that V survives every logical operation. The carry rules cannot be checked that way, because they depend on the operand values. These are the unsigned no-borrow meaning for subtraction, the last shifted-out bit, and the zero-shift case that keeps C. The overflow values and the exact results likewise depend on the operands. The bench scenarios show all of these by comparing them against independently computed values, both in directed boundary cases and in seeded random traffic.

// File: rtl/flagcmp_unit.sv
module flagcmp_unit #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic [2:0]           op,
  input  logic                 set_flags,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic                 shift_right,
  input  logic [$clog2(W)-1:0] shift_amt,
  output logic [W-1:0]         result,
  output logic                 result_we,
  output logic [3:0]           flags
);
  localparam int SW = $clog2(W);

  typedef enum logic [2:0] {
    OP_AND = 3'd0, OP_XOR = 3'd1, OP_SUB = 3'd2, OP_ADD = 3'd3,
    OP_TST = 3'd4, OP_TEQ = 3'd5, OP_CMP = 3'd6, OP_CMN = 3'd7
  } op_e;

  op_e          opc;
  logic [W:0]   lsh, rsh;
  logic [W-1:0] sh_val, opb;
  logic         sh_c;
  logic         is_sub, is_arith, upd;
  logic [W:0]   sum;
  logic         c_in_msb, v_arith;
  logic [3:0]   nxt;

  assign opc = op_e'(op);

  // operand shifter with carry-out
  assign lsh    = {1'b0, b} << shift_amt;
  assign rsh    = {b, 1'b0} >> shift_amt;
  assign sh_val = shift_right ? rsh[W:1] : lsh[W-1:0];
  assign sh_c   = (shift_amt == SW'(0)) ? flags[1] :
                  (shift_right ? rsh[0] : lsh[W]);

  // adder, shared by add/sub/compare
  assign is_sub   = (opc == OP_SUB) || (opc == OP_CMP);
  assign is_arith = op[1];
  assign opb      = is_sub ? ~sh_val : sh_val;
  assign sum      = {1'b0, a} + {1'b0, opb} + {{W{1'b0}}, is_sub};
  assign c_in_msb = a[W-1] ^ opb[W-1] ^ sum[W-1];
  assign v_arith  = c_in_msb ^ sum[W];

  always_comb begin
    unique case (opc)
      OP_AND, OP_TST: result = a & sh_val;
      OP_XOR, OP_TEQ: result = a ^ sh_val;
      default:        result = sum[W-1:0];
    endcase
  end

  assign result_we = valid & ~op[2];
  assign upd       = valid & (op[2] | set_flags);
  assign nxt = {result[W-1],
                result == '0,
                is_arith ? sum[W] : sh_c,
                is_arith ? v_arith : flags[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= 4'b0000;
    else if (upd) flags <= nxt;
  end

  // R9: reset value seen after release
  a_r9_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> flags == 4'b0000);
  // R8, R9: no update request leaves the register alone
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && (op[2] || set_flags)) |=> $stable(flags));
  // R3: N and Z follow the result that was written
  a_r3_n_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (op[2] || set_flags)) |=> flags[3] == $past(result[W-1]));
  a_r3_z_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (op[2] || set_flags)) |=> flags[2] == ($past(result) == '0));
  // R7: V survives logical operations
  a_r7_v_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !op[1]) |=> flags[0] == $past(flags[0]));
endmodule

// File: tb/tb_flagcmp_unit.sv
module tb_flagcmp_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid = 0;
  logic [2:0]  op = 0;
  logic        set_flags = 0;
  logic [31:0] a = 0, b = 0;
  logic        shift_right = 0;
  logic [4:0]  shift_amt = 0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags;

  int nvec = 0, nbad = 0;
  logic [3:0] mflags = 4'b0000;

  flagcmp_unit dut (.clk(clk), .rst_n(rst_n), .valid(valid), .op(op),
    .set_flags(set_flags), .a(a), .b(b), .shift_right(shift_right),
    .shift_amt(shift_amt), .result(result), .result_we(result_we), .flags(flags));

  always #10 clk = ~clk;

  initial begin
    #3000000;
    nbad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  function automatic logic [32:0] shf(input logic [31:0] v, input logic r,
                                      input logic [4:0] k, input logic cin);
    logic [63:0] t;
    if (k == 0) return {cin, v};
    if (!r) begin t = {32'b0, v} << k; return {t[32], t[31:0]}; end
    t = {v, 32'b0} >> k;
    return {t[31], t[63:32]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic sf, input logic [31:0] x,
                     input logic [31:0] y, input logic dir, input logic [4:0] k,
                     input logic v = 1);
    logic [32:0] s;
    logic [31:0] sv, r;
    logic c, ov, we;
    logic [3:0] nf;
    @(negedge clk);
    valid = v; op = o; set_flags = sf; a = x; b = y; shift_right = dir; shift_amt = k;
    s = shf(y, dir, k, mflags[1]);
    sv = s[31:0];
    c = mflags[1]; ov = mflags[0];
    case (o)
      3'd0, 3'd4: begin r = x & sv; c = s[32]; end
      3'd1, 3'd5: begin r = x ^ sv; c = s[32]; end
      3'd2, 3'd6: begin
        r = x - sv; c = (x >= sv);
        ov = (x[31] != sv[31]) && (r[31] != x[31]);
      end
      default: begin
        r = x + sv; c = ({1'b0, x} + {1'b0, sv}) > 33'hFFFFFFFF;
        ov = (x[31] == sv[31]) && (r[31] != x[31]);
      end
    endcase
    we = v && !o[2];
    nf = {r[31], r == 0, c, ov};
    #2;
    chk("R1 result", result, r);
    chk("R2 result_we", {31'b0, result_we}, {31'b0, we});
    @(posedge clk);
    if (v && (o[2] || sf)) mflags = nf;
    #2;
    chk("R3/R4/R5/R6/R7/R8/R9 flags", {28'b0, flags}, {28'b0, mflags});
    valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset flags", {28'b0, flags}, 32'h0);
    rst_n = 1;
    @(posedge clk); #2;
    chk("R9 flags after release", {28'b0, flags}, 32'h0);

    // R5 compare examples, R10 compare-negated example
    run(3'd6, 0, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 0);
    chk("R5 cmp flags 1001", {28'b0, flags}, 32'h9);
    run(3'd6, 0, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 2);
    chk("R5 cmp lsl2 flags 1001", {28'b0, flags}, 32'h9);
    run(3'd7, 0, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 2);
    chk("R10 cmn result", result, 32'h7FFFFFFB);
    chk("R10 cmn flags 0010", {28'b0, flags}, 32'h2);
    // R6 shifter carry, R7 V kept
    run(3'd6, 0, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 0); // V=1 first
    run(3'd4, 0, 32'h7FFFFFFF, 32'hFFFFFFFF, 1, 1);
    chk("R6 tst lsr1 C=1, R7 V kept", {28'b0, flags}, 32'h3);
    run(3'd5, 0, 32'h7FFFFFFF, 32'hFFFFFFFF, 1, 1);
    chk("R6 teq Z=1 C=1", {28'b0, flags}, 32'h7);
    run(3'd4, 0, 32'h0000FFFF, 32'h00000001, 0, 0);
    chk("R6 shift 0 keeps C", {28'b0, flags}, 32'h3);
    // R4 borrow meaning
    run(3'd6, 0, 32'h5, 32'h5, 0, 0);
    chk("R4 equal cmp C=1 Z=1", {28'b0, flags}, 32'h6);
    run(3'd6, 0, 32'h4, 32'h5, 0, 0);
    chk("R4 lower cmp C=0", {28'b0, flags}, 32'h8);
    // R8 set_flags off holds
    run(3'd3, 0, 32'hFFFFFFFF, 32'h1, 0, 0);
    chk("R8 add without set_flags", {28'b0, flags}, 32'h8);
    run(3'd3, 1, 32'hFFFFFFFF, 32'h1, 0, 0);
    chk("R8 add with set_flags", {28'b0, flags}, 32'h6);
    // R9 valid low holds, R2 no write
    run(3'd6, 1, 32'h4, 32'h5, 0, 0, 0);
    chk("R9 valid low holds", {28'b0, flags}, 32'h6);
    run(3'd1, 1, 32'h80000000, 32'h80000000, 1, 31);

    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      run(3'($urandom), 1'($urandom), $urandom, $urandom,
          1'($urandom), 5'($urandom), ($urandom % 8) != 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule